// File: doc/BRIEF.md
# Store Queue Between a Write-Through Cache and Memory

This block sits on the memory side of a write-through, write-around data cache. Every processor store is sent to memory. A store whose line is present also updates the cache, but that happens outside this block. A store miss never fills the cache and only reaches this queue. The queue takes each store as an address/data pair in a single cycle, so the processor goes on at once. The queue then hands the pairs to memory one at a time, oldest first, over a valid/ready handshake.

Pending stores are not yet visible in memory. A processor read that has to go to memory therefore probes the queue in the same cycle. If one or more live entries hold the probed address, the data of the most recently accepted one is returned. Repeated stores to one address each take their own entry and are never merged, so memory sees every write in program order. When all entries are occupied, the store-ready output drops and the processor waits until memory accepts the oldest entry.

Top module: `wbuf_top`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `mem_valid` is 0 and `rd_hit` is 0.
- R2: Accepted stores are presented on `mem_addr`/`mem_data` strictly in the order they were accepted. Each store is presented exactly once.
- R3: `mem_valid` is 1 whenever at least one store is pending. While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr` and `mem_data` hold their values. A handshake (`mem_valid` and `mem_ready` both 1 at a rising edge) retires the oldest entry.
- R4: A store is accepted at the rising edge where `st_valid` and `st_ready` are both 1. It needs no response from memory. `st_ready` stays 1 while fewer than DEPTH (default 4) entries are pending.
- R5: With DEPTH entries pending, `st_ready` is 0. A store offered in that state is ignored: it never reaches memory and cannot be found by a read probe.
- R6: When `rd_valid` is 1 and a pending entry has address `rd_addr`, `rd_hit` is 1 and `rd_data` carries its data in the same cycle. Otherwise `rd_hit` is 0 and `rd_data` is 0. When `rd_valid` is 0, `rd_hit` is 0.
- R7: When several pending entries match the probe, `rd_data` is the data of the most recently accepted one.
- R8: A store to an address that is already pending takes a new entry. Both writes later reach memory, in order.
- R9: Once an entry has been handed to memory, a probe no longer matches it.
- R10: A store and a drain at the same edge are both performed. The pending count is unchanged, and the new store goes to the back of the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor offers a store |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Queue can accept a store (not full) |
| rd_valid | input | 1 | Read probe is active |
| rd_addr | input | ADDR_W | Address being read from memory |
| rd_hit | output | 1 | A pending store matches the probe |
| rd_data | output | DATA_W | Newest matching pending data, 0 on a miss |
| mem_valid | output | 1 | Oldest pending store is offered to memory |
| mem_addr | output | ADDR_W | Address of the oldest pending store |
| mem_data | output | DATA_W | Data of the oldest pending store |
| mem_ready | input | 1 | Memory accepts the offered store |

## Verification
A wrong pointer or a wrong occupancy count appears at the ports within one drain. The memory side then shows an address out of order, or repeats an address, or skips one. `st_ready` also falls at the wrong fill level. A stale live bit, or a scan of the slots in the wrong age order, appears in the same cycle as a read probe. The probe then hits on a store that has already drained, or returns older data where newer data exists. The bench therefore checks the probe before and after each drain, and it checks the drained sequence against its own ordered list.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // Slot that lies `off` places after `base` in a ring of `depth` slots.
  function automatic int unsigned ring_step(int unsigned base, int unsigned off,
                                            int unsigned depth);
    return (base + off) % depth;
  endfunction

  // Occupancy after one cycle of optional push and pop.
  function automatic int unsigned occupancy_next(int unsigned occ, logic push, logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction
endpackage

// File: rtl/wbuf_ring.sv
module wbuf_ring
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [ADDR_W-1:0]              push_addr,
  input  logic [DATA_W-1:0]              push_data,
  input  logic                           pop,
  output logic                           full,
  output logic                           empty,
  output logic [ADDR_W-1:0]              head_addr,
  output logic [DATA_W-1:0]              head_data,
  output logic [$clog2(DEPTH)-1:0]       head_ptr,
  output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr,
  output logic [DEPTH-1:0][DATA_W-1:0]   slot_data,
  output logic [DEPTH-1:0]               slot_live
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occ       <= '0;
      slot_live <= '0;
    end else begin
      if (pop) begin
        slot_live[rd_ptr] <= 1'b0;
        rd_ptr            <= PTR_W'(ring_step(32'(rd_ptr), 1, DEPTH));
      end
      if (push) begin
        slot_live[wr_ptr] <= 1'b1;
        wr_ptr            <= PTR_W'(ring_step(32'(wr_ptr), 1, DEPTH));
      end
      occ <= CNT_W'(occupancy_next(32'(occ), push, pop));
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[wr_ptr] <= push_addr;
      slot_data[wr_ptr] <= push_data;
    end
  end

  assign full      = (occ == CNT_W'(DEPTH));
  assign empty     = (occ == '0);
  assign head_ptr  = rd_ptr;
  assign head_addr = slot_addr[rd_ptr];
  assign head_data = slot_data[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH)); // R5
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push); // R5
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop); // R3
  AST_LIVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_live) == 32'(occ)); // R2
  AST_BALANCED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (occ == $past(occ))); // R10
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           probe_en,
  input  logic [ADDR_W-1:0]              probe_addr,
  input  logic [$clog2(DEPTH)-1:0]       head_ptr,
  input  logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0]   slot_data,
  input  logic [DEPTH-1:0]               slot_live,
  output logic                           hit,
  output logic [DATA_W-1:0]              hit_data
);
  localparam int PTR_W = $clog2(DEPTH);

  logic              found;
  logic [DATA_W-1:0] found_data;
  logic [PTR_W-1:0]  idx;

  // Scan from oldest to newest; a later match overrides an earlier one.
  always_comb begin
    found      = 1'b0;
    found_data = '0;
    idx        = '0;
    for (int unsigned k = 0; k < DEPTH; k++) begin
      idx = PTR_W'(ring_step(32'(head_ptr), k, DEPTH));
      if (slot_live[idx] && (slot_addr[idx] == probe_addr)) begin
        found      = 1'b1;
        found_data = slot_data[idx];
      end
    end
  end

  assign hit      = probe_en && found;
  assign hit_data = hit ? found_data : '0;

  AST_HIT_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (slot_live != '0)); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_data == '0)); // R6
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_ready,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ready
);
  localparam int PTR_W = $clog2(DEPTH);

  logic                         buf_full, buf_empty;
  logic                         enq_fire, drain_fire;
  logic [PTR_W-1:0]             head_ptr;
  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
  logic [DEPTH-1:0][DATA_W-1:0] slot_data;
  logic [DEPTH-1:0]             slot_live;

  assign st_ready   = !buf_full;
  assign enq_fire   = st_valid && !buf_full;
  assign mem_valid  = !buf_empty;
  assign drain_fire = mem_valid && mem_ready;

  wbuf_ring #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (enq_fire),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (drain_fire),
    .full      (buf_full),
    .empty     (buf_empty),
    .head_addr (mem_addr),
    .head_data (mem_data),
    .head_ptr  (head_ptr),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .slot_live (slot_live)
  );

  wbuf_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .probe_en   (rd_valid),
    .probe_addr (rd_addr),
    .head_ptr   (head_ptr),
    .slot_addr  (slot_addr),
    .slot_data  (slot_data),
    .slot_live  (slot_live),
    .hit        (rd_hit),
    .hit_data   (rd_data)
  );

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R3
  AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |=> mem_valid); // R4
  AST_PROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !rd_hit); // R6
endmodule

// File: tb/tb_wbuf_top.sv
module tb_wbuf_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, rd_valid, mem_ready;
  logic [31:0] st_addr, st_data, rd_addr;
  logic        st_ready, rd_hit, mem_valid;
  logic [31:0] rd_data, mem_addr, mem_data;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  wbuf_top dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        hit;
    logic [31:0] data;
  } probe_vec_t;

  // Expected probes with the queue holding, oldest first:
  // 0x100/0x11, 0x200/0x22, 0x100/0x33, 0x300/0x44
  localparam probe_vec_t VEC [6] = '{
    '{addr: 32'h100, hit: 1'b1, data: 32'h33},  // R7 newest of two
    '{addr: 32'h200, hit: 1'b1, data: 32'h22},  // R6
    '{addr: 32'h300, hit: 1'b1, data: 32'h44},  // R6
    '{addr: 32'h400, hit: 1'b0, data: 32'h0},   // R6 miss
    '{addr: 32'h104, hit: 1'b0, data: 32'h0},   // R6 near miss
    '{addr: 32'h0,   hit: 1'b0, data: 32'h0}    // R6 unused address
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    tick();
    st_valid = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [31:0] a,
                       input logic eh, input logic [31:0] ed);
    rd_valid = 1'b1; rd_addr = a;
    #1;
    chk({tag, " hit"}, 32'(rd_hit), 32'(eh));
    chk({tag, " data"}, rd_data, ed);
    rd_valid = 1'b0;
  endtask

  task automatic drain_one(input string tag, input logic [31:0] ea, input logic [31:0] ed);
    chk({tag, " mem_valid"}, 32'(mem_valid), 32'h1);
    chk({tag, " mem_addr"}, mem_addr, ea);
    chk({tag, " mem_data"}, mem_data, ed);
    mem_ready = 1'b1;
    tick();
    mem_ready = 1'b0;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; rd_valid = 1'b0; mem_ready = 1'b0;
    st_addr = '0; st_data = '0; rd_addr = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 st_ready", 32'(st_ready), 32'h1);
    chk("R1 mem_valid", 32'(mem_valid), 32'h0);
    probe("R1 probe", 32'h0, 1'b0, 32'h0);

    // R4 stores are taken without memory response; R8 duplicate address
    store(32'h100, 32'h11);
    chk("R4 accepted one", 32'(mem_valid), 32'h1);
    store(32'h200, 32'h22);
    store(32'h100, 32'h33);
    chk("R4 ready at three", 32'(st_ready), 32'h1);
    store(32'h300, 32'h44);
    chk("R5 full stall", 32'(st_ready), 32'h0);

    // R3 head held while memory not ready
    tick();
    chk("R3 head held addr", mem_addr, 32'h100);
    chk("R3 head held data", mem_data, 32'h11);

    // Table of probes
    foreach (VEC[i]) probe("R6/R7 table", VEC[i].addr, VEC[i].hit, VEC[i].data);

    // R6 probe disabled gives no hit
    rd_valid = 1'b0; rd_addr = 32'h200; #1;
    chk("R6 probe off", 32'(rd_hit), 32'h0);

    // R5 store while full is ignored
    store(32'h500, 32'h55);
    probe("R5 ignored probe", 32'h500, 1'b0, 32'h0);

    // R2 drain oldest first; R9 drained entry stops matching
    drain_one("R2 first", 32'h100, 32'h11);
    chk("R5 ready after drain", 32'(st_ready), 32'h1);
    probe("R9 newer dup remains", 32'h100, 1'b1, 32'h33);
    drain_one("R2 second", 32'h200, 32'h22);
    probe("R9 drained 200", 32'h200, 1'b0, 32'h0);
    drain_one("R8 dup reaches memory", 32'h100, 32'h33);
    probe("R9 drained 100", 32'h100, 1'b0, 32'h0);
    drain_one("R2 fourth", 32'h300, 32'h44);
    chk("R5 ignored never drains", 32'(mem_valid), 32'h0);
    probe("R9 empty probe", 32'h300, 1'b0, 32'h0);

    // R10 store and drain in the same cycle
    store(32'h10, 32'h1);
    mem_ready = 1'b1;
    st_valid = 1'b1; st_addr = 32'h20; st_data = 32'h2;
    tick();
    st_valid = 1'b0; mem_ready = 1'b0;
    #1;
    chk("R10 new head addr", mem_addr, 32'h20);
    chk("R10 new head data", mem_data, 32'h2);
    probe("R10 old gone", 32'h10, 1'b0, 32'h0);
    probe("R10 new present", 32'h20, 1'b1, 32'h2);
    drain_one("R10 drain", 32'h20, 32'h2);
    chk("R10 empty", 32'(mem_valid), 32'h0);

    // R1 reset clears pending entries
    store(32'h30, 32'h3);
    rst_n = 1'b0; tick(); rst_n = 1'b1; #1;
    chk("R1 reset clears", 32'(mem_valid), 32'h0);
    probe("R1 reset probe", 32'h30, 1'b0, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule